// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block drives the raster timing of a video output from a pair of pixel-clock counters, one per axis. Each axis passes through four programmable phases: sync, back porch, active data and front porch. The horizontal sequencer advances once per clock. The vertical sequencer advances once per completed line. Sync, data enable and pixel data each have their own output polarity. The block also carries a pixel-clock inversion flag for the output pad stage.

Pixels come from a show-ahead FIFO read port. In each active clock the block shows the word at the head of the FIFO and pops it in the same cycle. If the FIFO is empty when a pixel is needed, the block raises a one-cycle underrun pulse. For the rest of that frame it stops reading and repeats the last good pixel. Normal reads resume with the next frame. Event pulses mark the start of vsync, the end of vsync and the end of each frame.

Each axis sequencer has two named states. In the `run` state it holds one of the phases PH_SYNC, PH_BACK, PH_ACTIVE and PH_FRONT, which step in that order. A phase advances when its count reaches the programmed length, and PH_FRONT wraps back to PH_SYNC. The pixel path has two states. PX_STREAM moves to PX_STARVED on an empty FIFO during a needed pixel. PX_STARVED moves back to PX_STREAM at the last cycle of the frame or when the block is disabled. A frame-end cycle also returns PX_STREAM to itself.

Top module: `disp_timing_gen`

## Requirements
- R1: On each axis the phases follow the order sync, back porch, active, front porch, and then wrap back to sync.
- R2: A programmed length N (12 bits) keeps its phase for N+1 counting steps, so one line lasts (sum of the four horizontal lengths + 4) clocks.
- R3: The vertical sequencer advances once per line, so one frame lasts (sum of the four vertical lengths + 4) lines. Vsync is active during the vertical sync phase.
- R4: Data enable is active only while both axes are in their active phase. In each such clock with the FIFO non-empty and no underrun, fifo_rd pulses and the pixel output shows fifo_data in that same cycle. Outside data enable the raw pixel is zero.
- R5: Each bit of pol_sel selects active-high (1) or active-low (0) for one output: bit 0 vsync, bit 1 hsync, bit 2 data enable. Bit 3 set inverts every bit of pix_o. When enabled, pclk_inv_o equals bit 4.
- R6: When data enable is active, the FIFO is empty and no underrun is pending, ev_underrun pulses for that one cycle and fifo_rd stays low. fifo_rd is never high while the FIFO is empty.
- R7: After an underrun, for the rest of that frame, fifo_rd stays low and every active pixel repeats the last pixel that was read, even if the FIFO refills.
- R8: The underrun state clears after the last cycle of the frame. The next frame reads the FIFO normally.
- R9: ev_vs_begin pulses in the first cycle of each frame. ev_vs_end pulses in the last cycle of the vertical sync phase. ev_frame_done pulses in the last cycle of the frame.
- R10: While enable is low, the sync and data-enable outputs sit at their inactive levels, the raw pixel is zero, fifo_rd and all events are low, and both counters are held at zero. On enable, the frame starts at the first sync cycle.
- R11: After reset, with enable low, all outputs are inactive. The first enabled cycle is the first cycle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the raster; low holds everything idle |
| h_sync_len | input | 12 | Horizontal sync length minus one |
| h_back_len | input | 12 | Horizontal back porch length minus one |
| h_act_len | input | 12 | Horizontal active length minus one |
| h_front_len | input | 12 | Horizontal front porch length minus one |
| v_sync_len | input | 12 | Vertical sync lines minus one |
| v_back_len | input | 12 | Vertical back porch lines minus one |
| v_act_len | input | 12 | Vertical active lines minus one |
| v_front_len | input | 12 | Vertical front porch lines minus one |
| pol_sel | input | 5 | Polarity selects (see R5) |
| fifo_empty | input | 1 | Pixel FIFO has no word |
| fifo_data | input | 24 | Pixel word at the FIFO head |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_o | output | 24 | Pixel data |
| pclk_inv_o | output | 1 | Pixel clock inversion flag |
| ev_vs_begin | output | 1 | First cycle of a frame |
| ev_vs_end | output | 1 | Last cycle of vertical sync |
| ev_frame_done | output | 1 | Last cycle of a frame |
| ev_underrun | output | 1 | Pixel needed with an empty FIFO |

## Verification
The raster is run under three timing sets. One uses multi-cycle phases. One uses zero-length phases next to each other, so several phases last a single cycle. One has a one-clock active width and a multi-line vertical active region. Together these separate an off-by-one in a phase length from an error in the phase order. Each timing set runs with a different polarity word: all active-high, all active-low, and a mixed word. A swapped or dropped polarity bit therefore shows up on a specific pin. A single empty-FIFO cycle on the first active pixel of a frame tests three things: the underrun pulse, the freeze on the last pixel while the FIFO refills, and the restart of reads in the next frame. Gaps with enable low between runs test that the outputs go idle and the counters restart.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_t;

    typedef enum logic {
        PX_STREAM  = 1'b0,
        PX_STARVED = 1'b1
    } pix_state_t;

    localparam int POL_VSYNC = 0;
    localparam int POL_HSYNC = 1;
    localparam int POL_DE    = 2;
    localparam int POL_DATA  = 3;
    localparam int POL_PCLK  = 4;
    localparam int POL_BITS  = 5;

    function automatic phase_t phase_after(input phase_t p);
        phase_t r;
        unique case (p)
            PH_SYNC:   r = PH_BACK;
            PH_BACK:   r = PH_ACTIVE;
            PH_ACTIVE: r = PH_FRONT;
            PH_FRONT:  r = PH_SYNC;
            default:   r = PH_SYNC;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/axis_seq.sv
module axis_seq
    import disp_timing_pkg::*;
#(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [TW-1:0] len_sync,
    input  logic [TW-1:0] len_back,
    input  logic [TW-1:0] len_act,
    input  logic [TW-1:0] len_front,
    output phase_t        phase,
    output logic [TW-1:0] count,
    output logic          seg_last,
    output logic          period_last
);

    logic [TW-1:0] cur_len;
    phase_t        nxt_phase;
    logic [TW-1:0] nxt_count;

    always_comb begin
        unique case (phase)
            PH_SYNC:   cur_len = len_sync;
            PH_BACK:   cur_len = len_back;
            PH_ACTIVE: cur_len = len_act;
            PH_FRONT:  cur_len = len_front;
            default:   cur_len = len_sync;
        endcase
    end

    assign seg_last    = (count == cur_len);
    assign period_last = seg_last && (phase == PH_FRONT);

    always_comb begin
        nxt_phase = phase;
        nxt_count = count;
        if (!run) begin
            nxt_phase = PH_SYNC;
            nxt_count = '0;
        end else if (step) begin
            if (seg_last) begin
                nxt_phase = phase_after(phase);
                nxt_count = '0;
            end else begin
                nxt_count = count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_SYNC;
            count <= '0;
        end else begin
            phase <= nxt_phase;
            count <= nxt_count;
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count <= cur_len));

    // R1
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (phase != $past(phase)))
            |-> (phase == phase_after($past(phase))));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (count == '0 && phase == PH_SYNC));

endmodule

// File: rtl/pixel_path.sv
module pixel_path
    import disp_timing_pkg::*;
#(
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          want,
    input  logic          frame_last,
    input  logic          fifo_empty,
    input  logic [PW-1:0] fifo_data,
    output logic          fifo_rd,
    output logic [PW-1:0] pix_raw,
    output logic          ev_underrun
);

    pix_state_t    state, nxt_state;
    logic [PW-1:0] last_pix;

    always_comb begin
        nxt_state = state;
        if (!run || frame_last) begin
            nxt_state = PX_STREAM;
        end else begin
            unique case (state)
                PX_STREAM:  if (want && fifo_empty) nxt_state = PX_STARVED;
                PX_STARVED: nxt_state = PX_STARVED;
                default:    nxt_state = PX_STREAM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PX_STREAM;
            last_pix <= '0;
        end else begin
            state <= nxt_state;
            if (fifo_rd) last_pix <= fifo_data;
        end
    end

    always_comb begin
        fifo_rd     = 1'b0;
        ev_underrun = 1'b0;
        pix_raw     = '0;
        unique case (state)
            PX_STREAM: begin
                fifo_rd     = want && !fifo_empty;
                ev_underrun = want && fifo_empty;
                if (want) pix_raw = fifo_empty ? last_pix : fifo_data;
            end
            PX_STARVED: begin
                if (want) pix_raw = last_pix;
            end
            default: ;
        endcase
    end

    // R6
    no_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_rd);

    // R7
    no_read_starved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PX_STARVED) |-> (!fifo_rd && !ev_underrun));

    // R6
    underrun_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_underrun && run && !frame_last) |=> (state == PX_STARVED));

    // R8
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |=> (state == PX_STREAM));

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import disp_timing_pkg::*;
#(
    parameter int TW = 12,
    parameter int PW = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [TW-1:0]       h_sync_len,
    input  logic [TW-1:0]       h_back_len,
    input  logic [TW-1:0]       h_act_len,
    input  logic [TW-1:0]       h_front_len,
    input  logic [TW-1:0]       v_sync_len,
    input  logic [TW-1:0]       v_back_len,
    input  logic [TW-1:0]       v_act_len,
    input  logic [TW-1:0]       v_front_len,
    input  logic [POL_BITS-1:0] pol_sel,
    input  logic                fifo_empty,
    input  logic [PW-1:0]       fifo_data,
    output logic                fifo_rd,
    output logic                hsync_o,
    output logic                vsync_o,
    output logic                de_o,
    output logic [PW-1:0]       pix_o,
    output logic                pclk_inv_o,
    output logic                ev_vs_begin,
    output logic                ev_vs_end,
    output logic                ev_frame_done,
    output logic                ev_underrun
);

    phase_t        h_phase, v_phase;
    logic [TW-1:0] h_count, v_count;
    logic          h_seg_last, h_line_last;
    logic          v_seg_last, v_frame_last;
    logic          frame_last;
    logic          hs_act, vs_act, de_act;
    logic [PW-1:0] pix_raw;

    axis_seq #(.TW(TW)) u_hseq (
        .clk(clk), .rst_n(rst_n), .run(enable), .step(1'b1),
        .len_sync(h_sync_len), .len_back(h_back_len),
        .len_act(h_act_len), .len_front(h_front_len),
        .phase(h_phase), .count(h_count),
        .seg_last(h_seg_last), .period_last(h_line_last)
    );

    axis_seq #(.TW(TW)) u_vseq (
        .clk(clk), .rst_n(rst_n), .run(enable), .step(h_line_last),
        .len_sync(v_sync_len), .len_back(v_back_len),
        .len_act(v_act_len), .len_front(v_front_len),
        .phase(v_phase), .count(v_count),
        .seg_last(v_seg_last), .period_last(v_frame_last)
    );

    assign frame_last = enable && h_line_last && v_frame_last;
    assign hs_act = enable && (h_phase == PH_SYNC);
    assign vs_act = enable && (v_phase == PH_SYNC);
    assign de_act = enable && (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);

    pixel_path #(.PW(PW)) u_pix (
        .clk(clk), .rst_n(rst_n), .run(enable), .want(de_act),
        .frame_last(frame_last), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .pix_raw(pix_raw), .ev_underrun(ev_underrun)
    );

    always_comb begin
        hsync_o       = hs_act ? pol_sel[POL_HSYNC] : !pol_sel[POL_HSYNC];
        vsync_o       = vs_act ? pol_sel[POL_VSYNC] : !pol_sel[POL_VSYNC];
        de_o          = de_act ? pol_sel[POL_DE]    : !pol_sel[POL_DE];
        pix_o         = pix_raw ^ {PW{pol_sel[POL_DATA]}};
        pclk_inv_o    = enable && pol_sel[POL_PCLK];
        ev_vs_begin   = vs_act && hs_act && (v_count == '0) && (h_count == '0);
        ev_vs_end     = vs_act && v_seg_last && h_line_last;
        ev_frame_done = frame_last;
    end

    // R4
    de_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (h_phase == PH_ACTIVE && v_phase == PH_ACTIVE && enable));

    // R9
    vs_end_then_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vs_end && enable) |=> (!enable || v_phase == PH_BACK));

    // R9
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_done && enable) |=> (!enable || ev_vs_begin));

endmodule

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;

    localparam int TW = 12;
    localparam int PW = 24;
    localparam int NCFG = 3;
    // hs hbp hact hfp vs vbp vact vfp pol
    localparam int CFG [NCFG][9] = '{
        '{1, 1, 3, 1, 0, 0, 1, 0, 31},
        '{0, 2, 1, 0, 1, 0, 0, 1, 0},
        '{2, 0, 0, 1, 0, 1, 2, 0, 10}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [TW-1:0] hl [4];
    logic [TW-1:0] vl [4];
    logic [4:0] pol = 5'd0;
    logic fifo_empty = 1'b0;
    logic [PW-1:0] fifo_data;
    logic fifo_rd, hsync_o, vsync_o, de_o, pclk_inv_o;
    logic [PW-1:0] pix_o;
    logic ev_vs_begin, ev_vs_end, ev_frame_done, ev_underrun;

    int n_checks = 0;
    int n_fail = 0;
    logic [PW-1:0] data_cnt = 24'hA00000;
    logic [PW-1:0] last_pix = '0;
    logic uf = 1'b0;

    assign fifo_data = data_cnt;

    always #2 clk = ~clk;

    disp_timing_gen #(.TW(TW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .h_sync_len(hl[0]), .h_back_len(hl[1]), .h_act_len(hl[2]), .h_front_len(hl[3]),
        .v_sync_len(vl[0]), .v_back_len(vl[1]), .v_act_len(vl[2]), .v_front_len(vl[3]),
        .pol_sel(pol), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .pix_o(pix_o), .pclk_inv_o(pclk_inv_o), .ev_vs_begin(ev_vs_begin),
        .ev_vs_end(ev_vs_end), .ev_frame_done(ev_frame_done), .ev_underrun(ev_underrun)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int phase_of(input int p, input int a, input int b, input int c);
        if (p < a + 1) return 0;
        if (p < a + b + 2) return 1;
        if (p < a + b + c + 3) return 2;
        return 3;
    endfunction

    task automatic check_idle(input string req);
        chk(req, "hsync idle", {31'd0, hsync_o}, {31'd0, !pol[1]});
        chk(req, "vsync idle", {31'd0, vsync_o}, {31'd0, !pol[0]});
        chk(req, "de idle", {31'd0, de_o}, {31'd0, !pol[2]});
        chk(req, "pix idle", {8'd0, pix_o}, {8'd0, {PW{pol[3]}}});
        chk(req, "rd/events idle",
            {27'd0, fifo_rd, pclk_inv_o, ev_vs_begin, ev_vs_end, ev_frame_done | ev_underrun},
            32'd0);
    endtask

    task automatic run_cfg(input int idx, input int frames, input int inject_t);
        int hlen, vlen, flen;
        for (int k = 0; k < 4; k++) begin
            hl[k] = TW'(CFG[idx][k]);
            vl[k] = TW'(CFG[idx][4 + k]);
        end
        pol = 5'(CFG[idx][8]);
        hlen = CFG[idx][0] + CFG[idx][1] + CFG[idx][2] + CFG[idx][3] + 4;
        vlen = CFG[idx][4] + CFG[idx][5] + CFG[idx][6] + CFG[idx][7] + 4;
        flen = hlen * vlen;
        uf = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        for (int t = 0; t < frames * flen; t++) begin
            int hp, ln, hph, vph, ft;
            logic e_hs, e_vs, e_de, e_rd, e_un;
            logic [PW-1:0] e_pix;
            fifo_empty = (t == inject_t);
            #1;
            ft = t % flen;
            hp = ft % hlen;
            ln = ft / hlen;
            hph = phase_of(hp, CFG[idx][0], CFG[idx][1], CFG[idx][2]);
            vph = phase_of(ln, CFG[idx][4], CFG[idx][5], CFG[idx][6]);
            e_hs = (hph == 0);
            e_vs = (vph == 0);
            e_de = (hph == 2) && (vph == 2);
            e_rd = e_de && !uf && !fifo_empty;
            e_un = e_de && !uf && fifo_empty;
            e_pix = !e_de ? '0 : (e_rd ? data_cnt : last_pix);
            // R1 R2: horizontal phase sequence and lengths
            chk("R2", "hsync", {31'd0, hsync_o}, {31'd0, e_hs ? pol[1] : !pol[1]});
            // R3: vertical sequence one step per line
            chk("R3", "vsync", {31'd0, vsync_o}, {31'd0, e_vs ? pol[0] : !pol[0]});
            // R4 R5: data enable window with polarity
            chk("R4", "de", {31'd0, de_o}, {31'd0, e_de ? pol[2] : !pol[2]});
            chk("R4", "fifo_rd", {31'd0, fifo_rd}, {31'd0, e_rd});
            // R5 R7 R8: pixel value with data polarity and freeze
            chk(uf ? "R7" : "R5", "pix", {8'd0, pix_o}, {8'd0, e_pix ^ {PW{pol[3]}}});
            chk("R5", "pclk_inv", {31'd0, pclk_inv_o}, {31'd0, pol[4]});
            chk("R6", "underrun", {31'd0, ev_underrun}, {31'd0, e_un});
            // R9: frame events
            chk("R9", "vs_begin", {31'd0, ev_vs_begin}, {31'd0, ft == 0});
            chk("R9", "vs_end", {31'd0, ev_vs_end}, {31'd0, ft == (CFG[idx][4] + 1) * hlen - 1});
            chk("R9", "frame_done", {31'd0, ev_frame_done}, {31'd0, ft == flen - 1});
            if (inject_t >= 0 && t >= flen && e_de)
                chk("R8", "reads resumed", {31'd0, fifo_rd}, 32'd1);
            @(posedge clk);
            #1;
            if (e_rd) begin
                last_pix = data_cnt;
                data_cnt = data_cnt + 24'd3;
            end
            if (e_un) uf = 1'b1;
            if (ft == flen - 1) uf = 1'b0;
            @(negedge clk);
        end
        fifo_empty = 1'b0;
        enable = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            check_idle("R10");
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            hl[k] = '0;
            vl[k] = '0;
        end
        pol = 5'b00101;
        repeat (3) @(negedge clk);
        #1;
        // R11: outputs idle in reset
        check_idle("R11");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle("R11");
        @(negedge clk);
        // table walk over timing and polarity sets
        for (int c = 0; c < NCFG; c++) run_cfg(c, 2, -1);
        // directed: underrun on the first active pixel of frame 0 (t = 24), R6 R7 R8
        run_cfg(0, 2, 24);
        // directed: enable restarts counters from frame start, R10
        run_cfg(1, 1, -1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule